// File: doc/BRIEF.md
# Reset-Time Configuration Sequencer

This block decides what the device does in the interval between the release of the active-low fundamental reset and normal operation. On the first clock edge after reset goes high it captures the strap pins. These are a 3-bit mode strap, a halt strap, and two groups of address straps. From the address straps it forms the 7-bit addresses that the management bus master and slave will use.

In image mode it drives a byte-wide read engine to fetch a configuration image from a serial EEPROM. Every fetched byte is added to an 8-bit checksum. The register writes are held in a staging buffer. They are released to the register file only when the whole image checks out. A bad image leaves the register file at its defaults and raises an error flag.

When the halt strap was set, the device stays parked after the sequence ends. It leaves that state only when software, through the slave bus, clears the halt control bit. A one-cycle pulse on `halt_clr` stands for that write. The `run_ok` output is the release-to-run signal for the rest of the chip.

Top module: `cfgseq_top`

## Requirements
- R1: While `rst_n` is low, `run_ok`, `rd_req`, `wr_valid`, `sum_err` and `mode_err` are all 0. Asserting `rst_n` returns the sequencer to its idle state asynchronously, without waiting for a clock.
- R2: The straps are captured on the first rising clock edge after `rst_n` goes high. Later changes on any strap pin have no effect until the next reset.
- R3: With address straps present (`HAS_ADDR_STRAPS`=1), `mst_addr` = {1,0,1,`mst_strap[3:0]`} and `slv_addr` = {1,1,`slv_strap[3]`,0,`slv_strap[2:0]`}. Without address straps, `mst_addr` is 7'h50 and `slv_addr` is 7'h77.
- R4: Mode strap value 0 performs no reads. `run_ok` rises after the second rising edge following reset release (when not halted) and then stays high.
- R5: Mode strap values 2 to 7 behave exactly like mode 0, and `mode_err` is set to 1.
- R6: Mode strap value 1 reads the image byte by byte, with `rd_addr` stepping up from 0 and `mst_addr` as the device address. The image layout is: a record count byte N, then N records of 3 bytes each (register address, data high byte, data low byte), then one checksum byte.
- R7: The 8-bit sum of all image bytes, including the count and checksum bytes, must be 0. If it is not, `sum_err` becomes 1, no register write is issued, and the sequence still goes on to release or halt. An image with N=0 and a correct checksum is valid and produces no writes.
- R8: A count byte larger than `MAX_RECS` stops the load after that single byte and sets `sum_err`. No writes are issued.
- R9: For a valid image, the writes appear only after the last image byte has been read. There is one write per consecutive cycle, in image order, with `wr_addr`/`wr_data` taken from the records.
- R10: With the halt strap set, `run_ok` stays 0 after the sequence. It rises one cycle after a `halt_clr` pulse received in the halted state. A `halt_clr` pulse before the halted state is reached is ignored.
- R11: A reset asserted in the middle of a load drops `rd_req` at once and discards the staged writes. The next release starts a fresh sequence with a fresh strap sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low fundamental reset, asynchronous |
| mode_strap | input | 3 | Operating mode strap |
| halt_strap | input | 1 | Park-after-reset strap |
| mst_strap | input | 4 | Master (EEPROM) address strap bits |
| slv_strap | input | 4 | Slave address strap bits |
| halt_clr | input | 1 | Pulse: software cleared the halt control bit |
| rd_req | output | 1 | Read engine request, held until `rd_done` |
| rd_addr | output | ROM_AW | Image byte offset requested |
| rd_done | input | 1 | Read engine returns one byte |
| rd_data | input | 8 | Byte returned |
| wr_valid | output | 1 | Register write command valid |
| wr_addr | output | REG_AW | Register address of the write |
| wr_data | output | REG_DW | Register data of the write |
| mst_addr | output | 7 | Latched EEPROM device address (also used by the read engine) |
| slv_addr | output | 7 | Latched slave bus address |
| run_ok | output | 1 | Release-to-run |
| sum_err | output | 1 | Image rejected (checksum or oversize count) |
| mode_err | output | 1 | Reserved mode strap value seen |

## Verification
The bench goes after these corner cases:
- **Late strap changes.** A latch that stays transparent after release would show the new address or start a load.
- **A checksum that is off by one.** A design that writes records as they arrive would leak writes before rejecting the image.
- **Oversized and empty record counts.** These probe overrunning the staging buffer and hanging while waiting for records that never come.
- **Early `halt_clr` and mid-load reset.** An early `halt_clr` pulse would release a halted device too soon in a design that remembers it. A reset in the middle of a load would let a stale request or a stale write survive in a design whose reset is not asynchronous across every stage.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE_RESET = 3'd0,
      ST_SAMPLE     = 3'd1,
      ST_LOAD       = 3'd2,
      ST_VERIFY     = 3'd3,
      ST_HALT       = 3'd4,
      ST_RUN        = 3'd5
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_COUNT  = 2'd0,
      PH_RECORD = 2'd1,
      PH_SUM    = 2'd2
   } img_phase_t;

   localparam logic [6:0] MST_ADDR_FIXED = 7'h50;
   localparam logic [6:0] SLV_ADDR_FIXED = 7'h77;
   localparam logic [2:0] MODE_PLAIN     = 3'd0;
   localparam logic [2:0] MODE_IMAGE     = 3'd1;

   function automatic logic [6:0] form_mst_addr(input logic [3:0] pins);
      return {3'b101, pins};
   endfunction

   function automatic logic [6:0] form_slv_addr(input logic [3:0] pins);
      return {2'b11, pins[3], 1'b0, pins[2:0]};
   endfunction

endpackage

// File: rtl/cfgseq_strap_latch.sv
module cfgseq_strap_latch
   import cfgseq_pkg::*;
#(
   parameter bit HAS_ADDR_STRAPS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lat_en,
   input  logic [2:0] mode_pins,
   input  logic       halt_pin,
   input  logic [3:0] mst_pins,
   input  logic [3:0] slv_pins,
   output logic [6:0] mst_addr,
   output logic [6:0] slv_addr,
   output logic       image_mode,
   output logic       halt_req,
   output logic       mode_err
);

   logic [2:0] mode_q;
   logic       halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_PLAIN;
         halt_q <= 1'b0;
      end else if (lat_en) begin
         mode_q <= mode_pins;
         halt_q <= halt_pin;
      end
   end

   assign image_mode = (mode_q == MODE_IMAGE);
   assign mode_err   = (mode_q != MODE_PLAIN) && (mode_q != MODE_IMAGE);
   assign halt_req   = halt_q;

   generate
      if (HAS_ADDR_STRAPS) begin : g_strapped
         logic [6:0] mst_q;
         logic [6:0] slv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mst_q <= MST_ADDR_FIXED;
               slv_q <= SLV_ADDR_FIXED;
            end else if (lat_en) begin
               mst_q <= form_mst_addr(mst_pins);
               slv_q <= form_slv_addr(slv_pins);
            end
         end
         assign mst_addr = mst_q;
         assign slv_addr = slv_q;
      end else begin : g_fixed
         logic unused_pins;
         assign unused_pins = ^{mst_pins, slv_pins};
         assign mst_addr    = MST_ADDR_FIXED;
         assign slv_addr    = SLV_ADDR_FIXED;
      end
   endgenerate

   AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_en |=> ($stable(mst_addr) && $stable(slv_addr) && $stable(mode_err))) // R2
      else $error("strap outputs moved after sampling");

endmodule

// File: rtl/cfgseq_fetch.sv
module cfgseq_fetch
   import cfgseq_pkg::*;
#(
   parameter int MAX_RECS  = 8,
   parameter int REC_BYTES = 3,
   parameter int ROM_AW    = 16,
   parameter int ROM_BASE  = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      rd_done,
   input  logic [7:0]                rd_data,
   output logic                      rd_req,
   output logic [ROM_AW-1:0]         rd_addr,
   output logic                      fin,
   output logic                      bad,
   output logic [7:0]                cnt,
   input  logic [$clog2(MAX_RECS)-1:0] stg_idx,
   output logic [REC_BYTES*8-1:0]    stg_rec
);

   localparam int IXW  = $clog2(MAX_RECS);
   localparam int IMAX = 2 + REC_BYTES * MAX_RECS;
   localparam int IW   = $clog2(IMAX + 1);
   localparam int RW   = REC_BYTES * 8;
   localparam int PW   = $clog2(REC_BYTES);
   localparam logic [PW-1:0] POS_LAST = PW'(REC_BYTES - 1);

   logic             busy_q, fin_q, bad_q;
   logic [7:0]       cnt_q, sum_q, rec_q;
   logic [IW-1:0]    idx_q;
   logic [PW-1:0]    pos_q;
   logic [RW-9:0]    sh_q;
   img_phase_t       ph_q;
   logic [RW-1:0]    stage_mem [MAX_RECS];

   logic             take;
   logic [7:0]       sum_nx;
   logic             stg_we;

   assign take   = busy_q && rd_done;
   assign sum_nx = sum_q + rd_data;
   assign stg_we = take && (ph_q == PH_RECORD) && (pos_q == POS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         fin_q  <= 1'b0;
         bad_q  <= 1'b0;
         cnt_q  <= '0;
         sum_q  <= '0;
         rec_q  <= '0;
         idx_q  <= '0;
         pos_q  <= '0;
         sh_q   <= '0;
         ph_q   <= PH_COUNT;
      end else if (start) begin
         busy_q <= 1'b1;
         fin_q  <= 1'b0;
         bad_q  <= 1'b0;
         cnt_q  <= '0;
         sum_q  <= '0;
         rec_q  <= '0;
         idx_q  <= '0;
         pos_q  <= '0;
         ph_q   <= PH_COUNT;
      end else if (take) begin
         idx_q <= idx_q + 1'b1;
         sum_q <= sum_nx;
         unique case (ph_q)
            PH_COUNT: begin
               cnt_q <= rd_data;
               if (rd_data > 8'(MAX_RECS)) begin
                  busy_q <= 1'b0;
                  fin_q  <= 1'b1;
                  bad_q  <= 1'b1;
               end else if (rd_data == 8'd0) begin
                  ph_q <= PH_SUM;
               end else begin
                  ph_q <= PH_RECORD;
               end
            end
            PH_RECORD: begin
               if (pos_q == POS_LAST) begin
                  pos_q <= '0;
                  rec_q <= rec_q + 8'd1;
                  if (rec_q == cnt_q - 8'd1) ph_q <= PH_SUM;
               end else begin
                  pos_q <= pos_q + 1'b1;
                  sh_q  <= {sh_q[RW-9:0], rd_data} >> 0;
               end
            end
            PH_SUM: begin
               busy_q <= 1'b0;
               fin_q  <= 1'b1;
               bad_q  <= (sum_nx != 8'd0);
            end
            default: ph_q <= PH_COUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (stg_we) stage_mem[rec_q[IXW-1:0]] <= {sh_q, rd_data};
   end

   assign rd_req  = busy_q;
   assign rd_addr = ROM_AW'(ROM_BASE) + ROM_AW'(idx_q);
   assign fin     = fin_q;
   assign bad     = bad_q;
   assign cnt     = cnt_q;
   assign stg_rec = stage_mem[stg_idx];

   AST_NO_STAGE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      stg_we |-> (rec_q < 8'(MAX_RECS))) // R8
      else $error("staging write past buffer end");

   AST_FIN_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> !rd_req) // R6
      else $error("request still open after image end");

endmodule

// File: rtl/cfgseq_commit.sv
module cfgseq_commit #(
   parameter int MAX_RECS = 8,
   parameter int REG_AW   = 8,
   parameter int REG_DW   = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        go,
   input  logic [7:0]                  cnt,
   output logic [$clog2(MAX_RECS)-1:0] stg_idx,
   input  logic [REG_AW+REG_DW-1:0]    stg_rec,
   output logic                        wr_valid,
   output logic [REG_AW-1:0]           wr_addr,
   output logic [REG_DW-1:0]           wr_data,
   output logic                        done
);

   localparam int IXW = $clog2(MAX_RECS);

   logic [7:0] ci_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ci_q <= '0;
      else if (!go)            ci_q <= '0;
      else if (ci_q < cnt)     ci_q <= ci_q + 8'd1;
   end

   assign stg_idx  = ci_q[IXW-1:0];
   assign wr_valid = go && (ci_q < cnt);
   assign done     = go && (ci_q == cnt);
   assign wr_addr  = stg_rec[REG_AW+REG_DW-1:REG_DW];
   assign wr_data  = stg_rec[REG_DW-1:0];

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
   import cfgseq_pkg::*;
#(
   parameter bit HAS_ADDR_STRAPS = 1'b1,
   parameter int MAX_RECS        = 8,
   parameter int REG_AW          = 8,
   parameter int REG_DW          = 16,
   parameter int ROM_AW          = 16,
   parameter int ROM_BASE        = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_strap,
   input  logic              halt_strap,
   input  logic [3:0]        mst_strap,
   input  logic [3:0]        slv_strap,
   input  logic              halt_clr,
   output logic              rd_req,
   output logic [ROM_AW-1:0] rd_addr,
   input  logic              rd_done,
   input  logic [7:0]        rd_data,
   output logic              wr_valid,
   output logic [REG_AW-1:0] wr_addr,
   output logic [REG_DW-1:0] wr_data,
   output logic [6:0]        mst_addr,
   output logic [6:0]        slv_addr,
   output logic              run_ok,
   output logic              sum_err,
   output logic              mode_err
);

   localparam int REC_BYTES = (REG_AW + REG_DW) / 8;
   localparam int IXW       = $clog2(MAX_RECS);

   initial begin : p_param_chk
      assert (MAX_RECS >= 2 && MAX_RECS <= 255) else $error("MAX_RECS out of range");
      assert (REG_AW % 8 == 0 && REG_DW % 8 == 0) else $error("widths must be whole bytes");
      assert (REG_AW >= 8 && REG_DW >= 8) else $error("record fields too narrow");
      assert (ROM_AW >= $clog2(2 + REC_BYTES * MAX_RECS + ROM_BASE + 1)) else $error("ROM_AW too small");
   end

   seq_state_t state_q, state_nx;
   logic       sum_err_q;
   logic       lat_en, image_mode, halt_req;
   logic       f_start, f_fin, f_bad;
   logic [7:0] f_cnt;
   logic       c_go, c_done;
   logic [IXW-1:0] stg_idx;
   logic [REG_AW+REG_DW-1:0] stg_rec;
   seq_state_t after_load;

   assign lat_en     = (state_q == ST_IDLE_RESET);
   assign f_start    = (state_q == ST_SAMPLE) && image_mode;
   assign c_go       = (state_q == ST_VERIFY) && !f_bad;
   assign after_load = halt_req ? ST_HALT : ST_RUN;

   cfgseq_strap_latch #(.HAS_ADDR_STRAPS(HAS_ADDR_STRAPS)) u_straps (
      .clk(clk), .rst_n(rst_n), .lat_en(lat_en),
      .mode_pins(mode_strap), .halt_pin(halt_strap),
      .mst_pins(mst_strap), .slv_pins(slv_strap),
      .mst_addr(mst_addr), .slv_addr(slv_addr),
      .image_mode(image_mode), .halt_req(halt_req), .mode_err(mode_err)
   );

   cfgseq_fetch #(.MAX_RECS(MAX_RECS), .REC_BYTES(REC_BYTES),
                  .ROM_AW(ROM_AW), .ROM_BASE(ROM_BASE)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(f_start),
      .rd_done(rd_done), .rd_data(rd_data),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .fin(f_fin), .bad(f_bad), .cnt(f_cnt),
      .stg_idx(stg_idx), .stg_rec(stg_rec)
   );

   cfgseq_commit #(.MAX_RECS(MAX_RECS), .REG_AW(REG_AW), .REG_DW(REG_DW)) u_commit (
      .clk(clk), .rst_n(rst_n), .go(c_go), .cnt(f_cnt),
      .stg_idx(stg_idx), .stg_rec(stg_rec),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(c_done)
   );

   always_comb begin
      state_nx = state_q;
      unique case (state_q)
         ST_IDLE_RESET: state_nx = ST_SAMPLE;
         ST_SAMPLE:     state_nx = image_mode ? ST_LOAD : after_load;
         ST_LOAD:       if (f_fin) state_nx = ST_VERIFY;
         ST_VERIFY:     if (f_bad || c_done) state_nx = after_load;
         ST_HALT:       if (halt_clr) state_nx = ST_RUN;
         ST_RUN:        state_nx = ST_RUN;
         default:       state_nx = ST_IDLE_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE_RESET;
         sum_err_q <= 1'b0;
      end else begin
         state_q <= state_nx;
         if (state_q == ST_VERIFY && f_bad) sum_err_q <= 1'b1;
      end
   end

   assign run_ok  = (state_q == ST_RUN);
   assign sum_err = sum_err_q;

   AST_REQ_ONLY_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (state_q == ST_LOAD)) // R6
      else $error("read request outside load");

   AST_NO_WRITE_BAD_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (!f_bad && f_fin)) // R7
      else $error("write from unverified image");

   AST_RESERVED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> !rd_req) // R5
      else $error("reserved mode started a load");

   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && !halt_clr) |=> !run_ok) // R10
      else $error("left halt without clear");

   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      run_ok |=> run_ok) // R4
      else $error("run release dropped");

   AST_WRITES_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !run_ok) // R9
      else $error("write after release");

endmodule

// File: tb/tb_cfgseq_top.sv
module tb_cfgseq_top;

   localparam int MAXR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_strap = 3'd0;
   logic        halt_strap = 1'b0;
   logic [3:0]  mst_strap = 4'd0;
   logic [3:0]  slv_strap = 4'd0;
   logic        halt_clr = 1'b0;
   logic        rd_req;
   logic [15:0] rd_addr;
   logic        rd_done = 1'b0;
   logic [7:0]  rd_data = 8'd0;
   logic        wr_valid;
   logic [7:0]  wr_addr;
   logic [15:0] wr_data;
   logic [6:0]  mst_addr, slv_addr;
   logic        run_ok, sum_err, mode_err;

   logic        f_rd_req, f_wr_valid, f_run_ok, f_sum_err, f_mode_err;
   logic [15:0] f_rd_addr;
   logic [7:0]  f_wr_addr;
   logic [15:0] f_wr_data;
   logic [6:0]  f_mst_addr, f_slv_addr;

   always #2.5 clk = ~clk;

   cfgseq_top #(.MAX_RECS(MAXR)) dut (
      .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .halt_strap(halt_strap),
      .mst_strap(mst_strap), .slv_strap(slv_strap), .halt_clr(halt_clr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .mst_addr(mst_addr), .slv_addr(slv_addr),
      .run_ok(run_ok), .sum_err(sum_err), .mode_err(mode_err)
   );

   cfgseq_top #(.HAS_ADDR_STRAPS(1'b0), .MAX_RECS(MAXR)) dut_fixed (
      .clk(clk), .rst_n(rst_n), .mode_strap(3'd0), .halt_strap(1'b0),
      .mst_strap(mst_strap), .slv_strap(slv_strap), .halt_clr(1'b0),
      .rd_req(f_rd_req), .rd_addr(f_rd_addr), .rd_done(1'b0), .rd_data(8'd0),
      .wr_valid(f_wr_valid), .wr_addr(f_wr_addr), .wr_data(f_wr_data),
      .mst_addr(f_mst_addr), .slv_addr(f_slv_addr),
      .run_ok(f_run_ok), .sum_err(f_sum_err), .mode_err(f_mode_err)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit ended    = 1'b0;

   logic [7:0]  img [0:63];
   int          img_len = 0;
   int          served = 0;
   logic [6:0]  exp_dev = 7'h50;
   logic [23:0] exp_q [$];
   int          cyc = 0;
   int          wr_n = 0, wr_first = 0, wr_last = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   // read engine model: answers one cycle after a request is seen
   initial begin
      int wait_cnt = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            rd_done  = 1'b0;
            wait_cnt = 0;
            served   = 0;
         end else if (rd_done) begin
            rd_done = 1'b0;
         end else if (rd_req) begin
            if (wait_cnt == 1) begin
               check(rd_addr == 16'(served), "R6 rd_addr", int'(rd_addr), served);
               check(mst_addr == exp_dev, "R6 device addr", int'(mst_addr), int'(exp_dev));
               rd_data  = img[rd_addr[5:0]];
               rd_done  = 1'b1;
               served   = served + 1;
               wait_cnt = 0;
            end else begin
               wait_cnt = wait_cnt + 1;
            end
         end else begin
            wait_cnt = 0;
         end
      end
   end

   // scoreboard monitor for register writes
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && wr_valid) begin
            check(served == img_len, "R9 write before image end", served, img_len);
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected write", int'({wr_addr, wr_data}), 0);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               check({wr_addr, wr_data} == e, "R9 write content", int'({wr_addr, wr_data}), int'(e));
            end
            if (wr_n == 0) wr_first = cyc;
            wr_last = cyc;
            wr_n    = wr_n + 1;
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   task automatic make_image(input int n, input bit corrupt);
      logic [7:0] s;
      exp_q.delete();
      wr_n = 0;
      for (int i = 0; i < 64; i++) img[i] = 8'h00;
      img[0] = 8'(n);
      s = 8'(n);
      if (n > MAXR) begin
         img_len = 1;
         return;
      end
      for (int i = 0; i < n; i++) begin
         logic [7:0]  a;
         logic [15:0] d;
         a = 8'(8'h10 + i * 3);
         d = 16'(16'hA05C + i * 16'h0111);
         img[1 + 3*i] = a;
         img[2 + 3*i] = d[15:8];
         img[3 + 3*i] = d[7:0];
         s = s + a + d[15:8] + d[7:0];
         if (!corrupt) exp_q.push_back({a, d});
      end
      img[1 + 3*n] = 8'(-s) + (corrupt ? 8'd1 : 8'd0);
      img_len = 2 + 3*n;
   endtask

   task automatic go_reset(input logic [2:0] m, input logic h,
                           input logic [3:0] ms, input logic [3:0] ss);
      @(negedge clk);
      rst_n      = 1'b0;
      mode_strap = m;
      halt_strap = h;
      mst_strap  = ms;
      slv_strap  = ss;
      exp_dev    = {3'b101, ms};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_run(input int limit);
      int k = 0;
      while (!run_ok && k < limit) begin
         @(negedge clk);
         k++;
      end
   endtask

   initial begin
      make_image(0, 1'b0);
      // R1: reset state
      repeat (3) @(negedge clk);
      check(run_ok == 0 && rd_req == 0 && wr_valid == 0, "R1 outputs in reset",
            int'({run_ok, rd_req, wr_valid}), 0);
      check(sum_err == 0 && mode_err == 0, "R1 flags in reset", int'({sum_err, mode_err}), 0);

      // R4, R3, R2: plain mode, late strap change
      go_reset(3'd0, 1'b0, 4'b1010, 4'b0101);
      @(posedge clk); @(negedge clk);
      check(run_ok == 0, "R4 no release after first edge", int'(run_ok), 0);
      mode_strap = 3'd1; mst_strap = 4'b0001; slv_strap = 4'b1111; halt_strap = 1'b1;
      @(posedge clk); @(negedge clk);
      check(run_ok == 1, "R4 release after second edge", int'(run_ok), 1);
      check(mst_addr == 7'h5A, "R3 master address", int'(mst_addr), 'h5A);
      check(slv_addr == 7'h65, "R3 slave address", int'(slv_addr), 'h65);
      check(f_mst_addr == 7'h50 && f_slv_addr == 7'h77, "R3 fixed addresses",
            int'({f_mst_addr, f_slv_addr}), int'({7'h50, 7'h77}));
      repeat (4) @(negedge clk);
      check(mst_addr == 7'h5A && slv_addr == 7'h65, "R2 straps frozen",
            int'({mst_addr, slv_addr}), int'({7'h5A, 7'h65}));
      check(served == 0 && run_ok == 1, "R2 no load after late mode change", served, 0);
      check(mode_err == 0, "R4 mode_err clear", int'(mode_err), 0);

      // R5: reserved mode
      go_reset(3'd6, 1'b0, 4'b0000, 4'b0000);
      @(posedge clk); @(posedge clk); @(negedge clk);
      check(run_ok == 1, "R5 reserved releases like mode 0", int'(run_ok), 1);
      check(mode_err == 1, "R5 mode_err set", int'(mode_err), 1);
      check(served == 0, "R5 no reads", served, 0);

      // R6, R9: valid image of three records
      make_image(3, 1'b0);
      go_reset(3'd1, 1'b0, 4'b0011, 4'b0000);
      wait_run(500);
      check(run_ok == 1, "R6 release after load", int'(run_ok), 1);
      check(served == 11, "R6 bytes read", served, 11);
      check(exp_q.size() == 0, "R9 all writes seen", exp_q.size(), 0);
      check(wr_n == 3 && (wr_last - wr_first) == 2, "R9 back-to-back writes",
            wr_last - wr_first, 2);
      check(sum_err == 0, "R7 good image no error", int'(sum_err), 0);

      // R7: corrupted checksum
      make_image(4, 1'b1);
      go_reset(3'd1, 1'b0, 4'b1100, 4'b0000);
      wait_run(500);
      check(run_ok == 1, "R7 release after bad image", int'(run_ok), 1);
      check(sum_err == 1, "R7 sum_err set", int'(sum_err), 1);
      check(wr_n == 0, "R7 no writes", wr_n, 0);

      // R7: empty image
      make_image(0, 1'b0);
      go_reset(3'd1, 1'b0, 4'b0110, 4'b0000);
      wait_run(200);
      check(run_ok == 1 && sum_err == 0, "R7 empty image accepted",
            int'({run_ok, sum_err}), 2);
      check(served == 2 && wr_n == 0, "R7 empty image two reads", served, 2);

      // R8: oversize count
      make_image(MAXR + 1, 1'b0);
      go_reset(3'd1, 1'b0, 4'b0000, 4'b0000);
      wait_run(200);
      check(sum_err == 1, "R8 oversize flagged", int'(sum_err), 1);
      check(served == 1, "R8 single read", served, 1);
      check(wr_n == 0, "R8 no writes", wr_n, 0);

      // R10: halt, early clear ignored
      make_image(0, 1'b0);
      go_reset(3'd0, 1'b1, 4'b0000, 4'b0000);
      @(posedge clk); #1 halt_clr = 1'b1;
      @(negedge clk); halt_clr = 1'b0;
      repeat (6) @(negedge clk);
      check(run_ok == 0, "R10 halted despite early clear", int'(run_ok), 0);
      halt_clr = 1'b1;
      @(posedge clk); @(negedge clk);
      halt_clr = 1'b0;
      check(run_ok == 1, "R10 release after clear", int'(run_ok), 1);

      // R11: reset during load
      make_image(5, 1'b0);
      go_reset(3'd1, 1'b0, 4'b0101, 4'b0000);
      while (served < 4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(rd_req == 0 && run_ok == 0, "R11 async stop", int'({rd_req, run_ok}), 0);
      check(1'b1, "R1 async reset observed", 0, 0);
      exp_q.delete();
      repeat (2) @(negedge clk);
      mode_strap = 3'd0; mst_strap = 4'b1001;
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check(run_ok == 1, "R11 fresh plain sequence", int'(run_ok), 1);
      check(mst_addr == 7'h59, "R11 fresh strap sample", int'(mst_addr), 'h59);
      repeat (3) @(negedge clk);
      check(wr_n == 0, "R11 staged writes dropped", wr_n, 0);

      finish_run();
   end

endmodule